// File: doc/BRIEF.md
# Dual-Modulus Prescaler

This block divides a fast input clock by a small ratio so that slower counters after it can run. It divides by either P or P+1. The modulus-control input picks which ratio applies, and a configuration bit sets P to 8 or to 32. The output is a single-cycle pulse, one per output period. That pulse clocks the swallow counter and the main counter that follow, and those counters send the modulus-control signal back to the prescaler.

The block has a synchronous divide-by-4/5 core at its centre. Binary toggle stages after the core count core cycles: one stage gives the 8/9 ratio and three stages give 32/33. Each core cycle is four input cycles. When modulus control is high, the last core cycle of the period is stretched to five input cycles, and this gives the extra input cycle. The modulus-control input is captured once per period, at a fixed point near the end of the period. A value that changes after that point therefore never splits a period.

Top module: `dual_mod_prescaler`

## Requirements
- R1: When the captured modulus control is 0, `div_o` pulses every P input cycles.
- R2: When the captured modulus control is 1, `div_o` pulses every P+1 input cycles. Exactly one core cycle in that period lasts five input cycles.
- R3: `psel_i` = 0 selects P = 8 and `psel_i` = 1 selects P = 32.
- R4: Number the cycles of a period from 0, where cycle 0 is the cycle in which `div_o` is high. `mod_i` is captured at the clock edge that ends cycle P-4, and that value sets the length of the period. A change made later applies from the next period.
- R5: `div_o` is high for exactly one input cycle per period.
- R6: `div_o` is low while `rst_ni` is low. After release, the first pulse appears P+`mod_i` rising edges later, where `mod_i` is the value held since reset.
- R7: `psel_i` changes only while `rst_ni` is low. The value present when reset is released sets P.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock to be divided |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | Ratio select: 0 gives 8/9, 1 gives 32/33 |
| mod_i | input | 1 | Modulus control: 0 divides by P, 1 by P+1 |
| div_o | output | 1 | One-cycle pulse per output period |

## Verification
On every cycle, the assertions check the following:
- each period is as long as P plus the modulus value present at cycle P-4;
- the core stretches once in a P+1 period and never in a P period;
- the pulse lasts a single cycle;
- `psel_i` stays still outside reset.

Three things are shown only by the bench scenarios:
- each change point of `mod_i` within a period is swept in both ratio modes, which shows where the capture boundary sits;
- the first period after reset release is measured;
- the ratio changes when `psel_i` is switched during reset.

// File: rtl/dmp_pkg.sv
package dmp_pkg;
  localparam int unsigned CORE_DIV = 4;
  localparam int unsigned PH_W     = 3;
  typedef logic [PH_W-1:0] ph_t;
  localparam ph_t PH_FIRST   = ph_t'(0);
  localparam ph_t PH_LAST    = ph_t'(CORE_DIV - 1);
  localparam ph_t PH_SWALLOW = ph_t'(CORE_DIV);
endpackage

// File: rtl/dmp_core45.sv
module dmp_core45
  import dmp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stretch_i,
  output ph_t  ph_o,
  output logic wrap_o
);
  ph_t ph_q;

  // Stretch at the last phase inserts one extra (swallow) phase.
  always_comb wrap_o = (ph_q == PH_SWALLOW) || ((ph_q == PH_LAST) && !stretch_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ph_q <= PH_FIRST;
    else if (wrap_o) ph_q <= PH_FIRST;
    else             ph_q <= ph_q + ph_t'(1);
  end

  assign ph_o = ph_q;
endmodule

// File: rtl/dmp_stage_chain.sv
module dmp_stage_chain #(
  parameter int unsigned STG_LO = 1,
  parameter int unsigned STG_HI = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hi_i,
  input  logic adv_i,
  output logic term_o
);
  logic [STG_HI-1:0] st_q;
  logic [STG_HI-1:0] act;
  logic [STG_HI-1:0] carry;

  for (genvar k = 0; k < STG_HI; k++) begin : g_stg
    if (k < STG_LO) begin : g_always
      assign act[k] = 1'b1;
    end else begin : g_hi_only
      assign act[k] = hi_i;
    end

    if (k == 0) begin : g_c0
      assign carry[k] = adv_i;
    end else begin : g_cn
      assign carry[k] = carry[k-1] & (st_q[k-1] | ~act[k-1]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       st_q[k] <= 1'b0;
      else if (!act[k])  st_q[k] <= 1'b0;
      else if (carry[k]) st_q[k] <= ~st_q[k];
    end
  end

  // Terminal when every active stage is at one.
  assign term_o = &(st_q | ~act);
endmodule

// File: rtl/dual_mod_prescaler.sv
module dual_mod_prescaler
  import dmp_pkg::*;
#(
  parameter int unsigned P_LO = 8,
  parameter int unsigned P_HI = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic psel_i,
  input  logic mod_i,
  output logic div_o
);
  localparam int unsigned STG_LO = $clog2(P_LO / CORE_DIV);
  localparam int unsigned STG_HI = $clog2(P_HI / CORE_DIV);

  ph_t  core_ph;
  logic core_wrap;
  logic term;
  logic mod_q;
  logic stretch;
  logic period_end;
  logic div_q;

  // Capture modulus once, at the start of the terminal core cycle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          mod_q <= 1'b0;
    else if (term && core_ph == PH_FIRST) mod_q <= mod_i;
  end

  assign stretch    = term & mod_q;
  assign period_end = core_wrap & term;

  dmp_core45 u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stretch_i (stretch),
    .ph_o      (core_ph),
    .wrap_o    (core_wrap)
  );

  dmp_stage_chain #(
    .STG_LO (STG_LO),
    .STG_HI (STG_HI)
  ) u_stages (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hi_i   (psel_i),
    .adv_i  (core_wrap),
    .term_o (term)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= 1'b0;
    else         div_q <= period_end;
  end

  assign div_o = div_q;
endmodule

// File: rtl/dual_mod_prescaler_chk.sv
module dual_mod_prescaler_chk
  import dmp_pkg::*;
#(
  parameter int unsigned P_LO = 8,
  parameter int unsigned P_HI = 32
) (
  input logic clk_i,
  input logic rst_ni,
  input logic psel_i,
  input logic mod_i,
  input logic div_o,
  input ph_t  core_ph_i
);
  logic [6:0] gap_q;
  logic [6:0] sw_q;
  logic       m_cap_q;
  logic [6:0] p_cur;

  assign p_cur = psel_i ? 7'(P_HI) : 7'(P_LO);

  // gap_q equals the cycle index within the period, except in the pulse cycle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q   <= '0;
      sw_q    <= '0;
      m_cap_q <= 1'b0;
    end else begin
      gap_q <= div_o ? 7'd1 : gap_q + 7'd1;
      sw_q  <= div_o ? 7'(core_ph_i == PH_SWALLOW) : sw_q + 7'(core_ph_i == PH_SWALLOW);
      if (!div_o && gap_q == p_cur - 7'd4) m_cap_q <= mod_i;
    end
  end

  a_r4_sampled_mod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |-> (gap_q == p_cur + 7'(m_cap_q)));

  a_r2_single_swallow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |-> (sw_q == gap_q - p_cur));

  a_r5_one_cycle_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |=> !div_o);

  a_r7_psel_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(psel_i));

  a_r1_period_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_o |-> (gap_q <= p_cur));
endmodule

bind dual_mod_prescaler dual_mod_prescaler_chk #(
  .P_LO (P_LO),
  .P_HI (P_HI)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .psel_i    (psel_i),
  .mod_i     (mod_i),
  .div_o     (div_o),
  .core_ph_i (core_ph)
);

// File: tb/dual_mod_prescaler_bench.sv
module dual_mod_prescaler_bench;
  logic clk_i  = 1'b0;
  logic rst_ni = 1'b0;
  logic psel_i = 1'b0;
  logic mod_i  = 1'b0;
  logic div_o;
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  always #5 clk_i = ~clk_i;

  dual_mod_prescaler u_dual_mod_prescaler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .psel_i (psel_i),
    .mod_i  (mod_i),
    .div_o  (div_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pval(input bit s);
    return s ? 32 : 8;
  endfunction

  // Reset, hold, release; ends at the negedge of the first pulse cycle.
  task automatic do_reset(input bit s, input bit m);
    int n;
    int exp;
    @(negedge clk_i);
    rst_ni = 1'b0;
    psel_i = s;
    mod_i  = m;
    repeat (3) @(negedge clk_i);
    chk(div_o == 1'b0, "R6 div_o low in reset", int'(div_o), 0);
    rst_ni = 1'b1;
    exp = pval(s) + int'(m);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!div_o && n < 100);
    chk(n == exp, $sformatf("R6 R7 R3 first period psel=%0d mod=%0d", s, m), n, exp);
  endtask

  // Starts at cycle 0 of a period; mod=m0 now, mod=m1 at cycle cc (cc>0).
  task automatic run_period(input bit m0, input int cc, input bit m1, input string req);
    int p;
    int exp;
    int c;
    p = pval(psel_i);
    exp = p + int'((cc > 0 && cc <= p - 4) ? m1 : m0);
    mod_i = m0;
    c = 0;
    do begin
      @(negedge clk_i);
      c++;
      if (c == 1) chk(div_o == 1'b0, "R5 pulse lasts one cycle", int'(div_o), 0);
      if (c == cc && !div_o) mod_i = m1;
    end while (!div_o && c < 100);
    chk(c == exp, $sformatf("%s psel=%0d m0=%0d cc=%0d m1=%0d", req, psel_i, m0, cc, m1), c, exp);
  endtask

  task automatic sweep_mode(input bit s);
    do_reset(s, 1'b0);
    for (int i = 0; i < 24; i++) begin
      bit m;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      m = lfsr[0];
      run_period(m, 0, m, m ? "R2 R3 divide by P+1" : "R1 R3 divide by P");
    end
    for (int cc = 1; cc < pval(s); cc++) begin
      for (int m0 = 0; m0 < 2; m0++) begin
        for (int m1 = 0; m1 < 2; m1++) begin
          run_period(bit'(m0), cc, bit'(m1), "R4 capture point");
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    sweep_mode(1'b0);
    sweep_mode(1'b1);
    do_reset(1'b0, 1'b1);
    run_period(1'b0, 0, 1'b0, "R1 R7 back to 8 after reset");
    do_reset(1'b1, 1'b1);
    run_period(1'b1, 0, 1'b1, "R2 R7 back to 32 after reset");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule